// File: doc/BRIEF.md
# Interrupt IN Complete-Split Host Handler

This block is the host-side sequencer that collects interrupt IN data from a transaction translator by means of complete-split attempts. Each attempt starts with a command strobe. The handler then places a CSPLIT token and an IN token on its token output, one cycle each, and waits for either a decoded upstream reply or a timeout. It classifies that reply and returns one response code that tells the scheduler what to do next: move to the next command, wait for the next scheduled complete-split, retry the complete-split at once, restart from the start-split, or halt the endpoint.

A full- or low-speed interrupt payload can reach the host in at most two pieces. The first piece arrives as MDATA and the closing piece as DATA0/DATA1. The handler keeps a running byte count of the data it has accepted. When any later failure occurs, it discards every piece held so far, so the failure covers the whole transaction. It also keeps the expected data toggle and a saturating error counter. The counter is cleared whenever a new command begins.

Top module: `intInSplitHost`

## Requirements
- R1: While idle, a high `cmdValid` starts an attempt. The cycle after it is sampled shows a CSPLIT token (`tokValid`=1, `tokKind`=0). The next cycle shows an IN token (`tokKind`=1). The handler then waits with `tokValid`=0. A `cmdValid` that arrives while an attempt is in progress is ignored.
- R2: Reply codes on `rxPid` are NYET=0, NAK=1, STALL=2, ERR=3, MDATA=4, DATA0=5, DATA1=6, and 7 for any other PID. While waiting, a sampled `rxValid` or `rxTimeout` makes `rspValid` high for exactly one cycle, in the following cycle, and the handler returns to idle. Replies that arrive while idle are ignored. Response codes are NEXT_CMD=0, NEXT_CS=1, RETRY=2, RESTART=3, HALT=4.
- R3: A STALL reply gives HALT and discards all held data.
- R4: The error path is taken on an ERR reply, on MDATA or DATA with `rxCrcOk`=0, on code 7, or on a timeout. A timeout takes precedence over a simultaneous `rxValid`. The error path increments `errCnt`, which saturates at 3. It answers RETRY if the count is still below 3 and HALT otherwise.
- R5: MDATA with a good CRC adds `rxLen` to `heldBytes` and answers NEXT_CS.
- R6: DATA0/DATA1 with a good CRC and a toggle equal to `expToggle` (DATA1 means toggle 1) adds `rxLen` to `heldBytes`, inverts `expToggle`, and answers NEXT_CMD. `expToggle` changes on no other event.
- R7: DATA0/DATA1 with a good CRC and the wrong toggle clears `heldBytes`, leaves `expToggle` unchanged, and answers NEXT_CMD.
- R8: NYET answers NEXT_CS and keeps held data, unless the attempt was flagged `cmdLast`. In that case it takes the error path.
- R9: Every error-path response clears `heldBytes`, including bytes accepted by an earlier MDATA of the same transaction.
- R10: An MDATA that arrives when a piece is already held takes the error path, because no transaction carries more than two data pieces.
- R11: A NAK reply answers RESTART and clears `heldBytes`.
- R12: After reset, `tokValid`, `rspValid`, `heldBytes`, `expToggle` and `errCnt` are all 0. An attempt started with `cmdNew`=1 clears `errCnt` and `heldBytes` before its reply is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Start a complete-split attempt |
| cmdNew | input | 1 | Attempt is the first of a new command |
| cmdLast | input | 1 | Attempt is the last scheduled complete-split |
| tokValid | output | 1 | Token request valid |
| tokKind | output | 1 | 0 = CSPLIT, 1 = IN |
| rxValid | input | 1 | Decoded upstream reply present |
| rxPid | input | 3 | Decoded reply code |
| rxCrcOk | input | 1 | Reply data CRC good |
| rxLen | input | 7 | Payload bytes in the reply |
| rxTimeout | input | 1 | No reply within the turnaround window |
| rspValid | output | 1 | Response code valid (one cycle) |
| rspCode | output | 3 | Response to the scheduler |
| heldBytes | output | 8 | Bytes accepted for the current transaction |
| expToggle | output | 1 | Expected data toggle |
| errCnt | output | 2 | Error counter |

## Verification
The hardest situation to reach is a failure that must cancel data already accepted from an earlier piece. To get there, the bench first has to complete an MDATA attempt that leaves bytes held. It then starts a second attempt of the same command with no reset of the held state, and feeds that attempt a bad CRC, a second MDATA, or a STALL. The saturated counter path has a similar difficulty. It needs three failed attempts in a row within one command, followed by a fourth failure, which shows that the count stays at 3 and the response stays HALT. A command pulse is also injected while the handler waits for a reply, to show that it does not disturb the held bytes.

// File: rtl/icsh_pkg.sv
package icsh_pkg;

  typedef enum logic [2:0] {
    PID_NYET  = 3'd0,
    PID_NAK   = 3'd1,
    PID_STALL = 3'd2,
    PID_ERR   = 3'd3,
    PID_MDATA = 3'd4,
    PID_DATA0 = 3'd5,
    PID_DATA1 = 3'd6,
    PID_OTHER = 3'd7
  } replyE;

  typedef enum logic [2:0] {
    RSP_NEXT_CMD = 3'd0,
    RSP_NEXT_CS  = 3'd1,
    RSP_RETRY    = 3'd2,
    RSP_RESTART  = 3'd3,
    RSP_HALT     = 3'd4
  } rspE;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_CSPL = 2'd1,
    S_INTK = 2'd2,
    S_WAIT = 2'd3
  } stE;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrAll;   // new command: clear counter and held data
    logic accept;   // add payload bytes as one more piece
    logic flip;     // invert expected toggle
    logic discard;  // drop all held pieces
    logic errInc;   // count one error
  } dpStrobeT;

endpackage

// File: rtl/icsh_ctrl.sv
module icsh_ctrl
  import icsh_pkg::*;
#(
  parameter int ERR_LIMIT = 3,
  parameter int CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdNew,
  input  logic             cmdLast,
  input  logic             rxValid,
  input  logic [2:0]       rxPid,
  input  logic             rxCrcOk,
  input  logic             rxTimeout,
  input  logic [CNT_W-1:0] errCnt,
  input  logic             heldAny,
  input  logic             expToggle,
  output logic             tokValid,
  output logic             tokKind,
  output logic             waitSt,
  output logic             rspValid,
  output logic [2:0]       rspCode,
  output dpStrobeT         strobe
);

  stE   st;
  logic lastQ;
  logic evt;
  logic goErr;
  logic limitHit;
  logic toggleOk;
  rspE  nextCode;

  assign tokValid = (st == S_CSPL) || (st == S_INTK);
  assign tokKind  = (st == S_INTK);
  assign waitSt   = (st == S_WAIT);
  assign evt      = waitSt && (rxValid || rxTimeout);
  assign limitHit = (int'(errCnt) + 1) >= ERR_LIMIT;
  assign toggleOk = ((rxPid == PID_DATA1) == expToggle);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st    <= S_IDLE;
      lastQ <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cmdValid) begin
          st    <= S_CSPL;
          lastQ <= cmdLast;
        end
        S_CSPL: st <= S_INTK;
        S_INTK: st <= S_WAIT;
        S_WAIT: if (evt) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe   = '0;
    goErr    = 1'b0;
    nextCode = RSP_NEXT_CMD;
    if (st == S_IDLE && cmdValid && cmdNew) strobe.clrAll = 1'b1;
    if (evt) begin
      if (rxTimeout) begin
        goErr = 1'b1;
      end else begin
        case (rxPid)
          PID_NYET: begin
            if (lastQ) goErr = 1'b1;
            else nextCode = RSP_NEXT_CS;
          end
          PID_NAK: begin
            nextCode       = RSP_RESTART;
            strobe.discard = 1'b1;
          end
          PID_STALL: begin
            nextCode       = RSP_HALT;
            strobe.discard = 1'b1;
          end
          PID_MDATA: begin
            if (!rxCrcOk || heldAny) goErr = 1'b1;
            else begin
              strobe.accept = 1'b1;
              nextCode      = RSP_NEXT_CS;
            end
          end
          PID_DATA0, PID_DATA1: begin
            if (!rxCrcOk) goErr = 1'b1;
            else if (toggleOk) begin
              strobe.accept = 1'b1;
              strobe.flip   = 1'b1;
              nextCode      = RSP_NEXT_CMD;
            end else begin
              strobe.discard = 1'b1;
              nextCode       = RSP_NEXT_CMD;
            end
          end
          default: goErr = 1'b1;
        endcase
      end
      if (goErr) begin
        strobe.errInc  = 1'b1;
        strobe.discard = 1'b1;
        nextCode       = limitHit ? RSP_HALT : RSP_RETRY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCode  <= RSP_NEXT_CMD;
    end else begin
      rspValid <= evt;
      if (evt) rspCode <= nextCode;
    end
  end

endmodule

// File: rtl/icsh_dpath.sv
module icsh_dpath
  import icsh_pkg::*;
#(
  parameter int ERR_LIMIT  = 3,
  parameter int MAX_PIECES = 2,
  parameter int LEN_W      = 7,
  parameter int HELD_W     = 8,
  parameter int CNT_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [LEN_W-1:0]  rxLen,
  output logic [HELD_W-1:0] heldBytes,
  output logic              heldAny,
  output logic              expToggle,
  output logic [CNT_W-1:0]  errCnt
);

  localparam int PC_W = $clog2(MAX_PIECES + 1);

  logic [PC_W-1:0] pieces;

  assign heldAny = (pieces != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCnt <= '0;
    end else if (strobe.clrAll) begin
      errCnt <= '0;
    end else if (strobe.errInc && int'(errCnt) < ERR_LIMIT) begin
      errCnt <= errCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldBytes <= '0;
      pieces    <= '0;
    end else if (strobe.clrAll || strobe.discard) begin
      heldBytes <= '0;
      pieces    <= '0;
    end else if (strobe.accept) begin
      heldBytes <= heldBytes + HELD_W'(rxLen);
      if (int'(pieces) < MAX_PIECES) pieces <= pieces + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) expToggle <= 1'b0;
    else if (strobe.flip) expToggle <= ~expToggle;
  end

endmodule

// File: rtl/intInSplitHost.sv
module intInSplitHost
  import icsh_pkg::*;
#(
  parameter  int MAX_BYTES = 64,
  parameter  int ERR_LIMIT = 3,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int HELD_W    = LEN_W + 1,
  localparam int CNT_W     = $clog2(ERR_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdNew,
  input  logic              cmdLast,
  output logic              tokValid,
  output logic              tokKind,
  input  logic              rxValid,
  input  logic [2:0]        rxPid,
  input  logic              rxCrcOk,
  input  logic [LEN_W-1:0]  rxLen,
  input  logic              rxTimeout,
  output logic              rspValid,
  output logic [2:0]        rspCode,
  output logic [HELD_W-1:0] heldBytes,
  output logic              expToggle,
  output logic [CNT_W-1:0]  errCnt
);

  localparam int MAX_PIECES = 2;

  dpStrobeT strobe;
  logic     heldAny;
  logic     waitSt;

  icsh_ctrl #(.ERR_LIMIT(ERR_LIMIT), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdNew(cmdNew), .cmdLast(cmdLast),
    .rxValid(rxValid), .rxPid(rxPid), .rxCrcOk(rxCrcOk), .rxTimeout(rxTimeout),
    .errCnt(errCnt), .heldAny(heldAny), .expToggle(expToggle),
    .tokValid(tokValid), .tokKind(tokKind), .waitSt(waitSt),
    .rspValid(rspValid), .rspCode(rspCode), .strobe(strobe)
  );

  icsh_dpath #(
    .ERR_LIMIT(ERR_LIMIT), .MAX_PIECES(MAX_PIECES),
    .LEN_W(LEN_W), .HELD_W(HELD_W), .CNT_W(CNT_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxLen(rxLen),
    .heldBytes(heldBytes), .heldAny(heldAny),
    .expToggle(expToggle), .errCnt(errCnt)
  );

endmodule

// File: rtl/intInSplitHost_chk.sv
module intInSplitHost_chk #(
  parameter int ERR_LIMIT = 3,
  parameter int HELD_W    = 8,
  parameter int CNT_W     = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              tokValid,
  input logic              tokKind,
  input logic              waitSt,
  input logic              rxValid,
  input logic [2:0]        rxPid,
  input logic              rxTimeout,
  input logic              rspValid,
  input logic [2:0]        rspCode,
  input logic [HELD_W-1:0] heldBytes,
  input logic              expToggle,
  input logic [CNT_W-1:0]  errCnt
);

  a_r1_in_after_csplit: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && !tokKind) |=> (tokValid && tokKind));

  a_r1_quiet_while_wait: assert property (@(posedge clk) disable iff (!rstN)
    waitSt |-> !tokValid);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  a_r2_reply_answered: assert property (@(posedge clk) disable iff (!rstN)
    (waitSt && (rxValid || rxTimeout)) |=> rspValid);

  a_r3_stall_halts: assert property (@(posedge clk) disable iff (!rstN)
    (waitSt && rxValid && !rxTimeout && rxPid == 3'd2)
      |=> (rspValid && rspCode == 3'd4 && heldBytes == '0));

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(errCnt) <= ERR_LIMIT);

  a_r6_toggle_on_data: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(expToggle) |-> (rspValid && rspCode == 3'd0));

  a_r9_fail_discards: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspCode == 3'd2 || rspCode == 3'd4)) |-> heldBytes == '0);

endmodule

bind intInSplitHost intInSplitHost_chk #(
  .ERR_LIMIT(ERR_LIMIT), .HELD_W(HELD_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokKind(tokKind),
  .waitSt(waitSt), .rxValid(rxValid), .rxPid(rxPid), .rxTimeout(rxTimeout),
  .rspValid(rspValid), .rspCode(rspCode), .heldBytes(heldBytes),
  .expToggle(expToggle), .errCnt(errCnt)
);

// File: tb/intInSplitHost_tb_top.sv
`timescale 1ns/100ps
module intInSplitHost_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0, cmdNew = 1'b0, cmdLast = 1'b0;
  logic       tokValid, tokKind;
  logic       rxValid = 1'b0;
  logic [2:0] rxPid = 3'd0;
  logic       rxCrcOk = 1'b0;
  logic [6:0] rxLen = 7'd0;
  logic       rxTimeout = 1'b0;
  logic       rspValid;
  logic [2:0] rspCode;
  logic [7:0] heldBytes;
  logic       expToggle;
  logic [1:0] errCnt;

  always #2.5 clk = ~clk;

  intInSplitHost dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdNew(cmdNew), .cmdLast(cmdLast),
    .tokValid(tokValid), .tokKind(tokKind), .rxValid(rxValid), .rxPid(rxPid),
    .rxCrcOk(rxCrcOk), .rxLen(rxLen), .rxTimeout(rxTimeout), .rspValid(rspValid),
    .rspCode(rspCode), .heldBytes(heldBytes), .expToggle(expToggle), .errCnt(errCnt)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  int mHeld = 0, mPieces = 0, mErr = 0;
  bit mTog = 0, mRspV = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(rspValid == mRspV, "R2 rspValid", rspValid, mRspV);
      chk(heldBytes == mHeld, "R9 heldBytes", heldBytes, mHeld);
      chk(expToggle == mTog, "R6 expToggle", expToggle, mTog);
      chk(errCnt == mErr, "R4 errCnt", errCnt, mErr);
    end
  end

  task automatic finishRun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  function automatic void modelClear();
    mHeld = 0;
    mPieces = 0;
  endfunction

  // One complete-split attempt; pid, crc, len and timeout describe the reply
  task automatic attempt(input bit nw, input bit lst, input int pid, input bit crc,
                         input int len, input bit tmo, input bit poke, input string tag);
    int code;
    bit bad;
    @(negedge clk);
    cmdValid = 1; cmdNew = nw; cmdLast = lst;
    @(posedge clk); #1;
    cmdValid = 0; cmdNew = 0;
    if (nw) begin mErr = 0; modelClear(); end
    @(negedge clk);
    chk(tokValid && !tokKind, "R1 CSPLIT token", {tokValid, tokKind}, 2);
    @(negedge clk);
    chk(tokValid && tokKind, "R1 IN token", {tokValid, tokKind}, 3);
    @(negedge clk);
    chk(!tokValid, "R1 wait quiet", tokValid, 0);
    rxValid = !tmo || (pid == 5);
    rxPid = 3'(pid); rxCrcOk = crc; rxLen = 7'(len); rxTimeout = tmo;
    if (poke) begin cmdValid = 1; cmdNew = 1; end
    @(posedge clk); #1;
    rxValid = 0; rxTimeout = 0; cmdValid = 0; cmdNew = 0;
    bad = 0; code = 0;
    if (tmo) bad = 1;
    else case (pid)
      0: if (lst) bad = 1; else code = 1;
      1: begin code = 3; modelClear(); end
      2: begin code = 4; modelClear(); end
      4: if (!crc || mPieces > 0) bad = 1;
         else begin mHeld += len; mPieces++; code = 1; end
      5, 6: if (!crc) bad = 1;
            else if ((pid == 6) == mTog) begin
              mHeld += len; mPieces++; mTog = !mTog; code = 0;
            end else begin modelClear(); code = 0; end
      default: bad = 1;
    endcase
    if (bad) begin
      if (mErr < 3) mErr++;
      modelClear();
      code = (mErr >= 3) ? 4 : 2;
    end
    mRspV = 1;
    @(negedge clk);
    chk(rspValid && rspCode == 3'(code), tag, rspCode, code);
    @(posedge clk); #1;
    mRspV = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!tokValid && !rspValid && heldBytes == 0 && !expToggle && errCnt == 0,
        "R12 reset state", {tokValid, rspValid, heldBytes, expToggle, errCnt}, 0);
    rstN = 1;
    // reply while idle is ignored
    @(negedge clk);
    rxValid = 1; rxPid = 3'd2;
    @(posedge clk); #1; rxValid = 0;
    @(negedge clk);
    chk(!rspValid, "R2 idle reply ignored", rspValid, 0);

    attempt(1, 0, 4, 1, 40, 0, 0, "R5 MDATA good -> NEXT_CS");
    attempt(0, 0, 5, 1, 24, 0, 0, "R6 DATA0 match -> NEXT_CMD");
    attempt(1, 0, 5, 1, 8, 0, 0, "R7 DATA0 mismatch -> NEXT_CMD");
    attempt(1, 0, 6, 1, 8, 0, 0, "R6 DATA1 match");
    attempt(1, 0, 0, 0, 0, 0, 0, "R8 NYET not last");
    attempt(0, 1, 0, 0, 0, 0, 0, "R8 NYET last -> error");
    attempt(1, 0, 4, 1, 30, 0, 0, "R5 MDATA before bad CRC");
    attempt(0, 0, 5, 0, 20, 0, 0, "R9 bad CRC drops earlier piece");
    attempt(1, 0, 4, 1, 10, 0, 0, "R5 first piece");
    attempt(0, 0, 4, 1, 10, 0, 0, "R10 second MDATA -> error");
    attempt(1, 0, 3, 0, 0, 0, 0, "R4 ERR reply retry");
    attempt(0, 0, 5, 1, 4, 1, 0, "R4 timeout wins over reply");
    attempt(0, 0, 7, 1, 0, 0, 0, "R4 third error halts");
    attempt(0, 0, 3, 0, 0, 0, 0, "R4 count saturates");
    attempt(1, 0, 4, 1, 20, 0, 0, "R5 piece before NAK");
    attempt(0, 0, 1, 0, 0, 0, 0, "R11 NAK -> RESTART");
    attempt(1, 0, 4, 1, 16, 0, 0, "R5 piece before STALL");
    attempt(0, 0, 2, 0, 0, 0, 0, "R3 STALL -> HALT");
    attempt(1, 0, 4, 1, 12, 0, 1, "R1 busy command ignored");
    attempt(0, 0, 5, 1, 4, 0, 0, "R6 closing DATA0 after poke");
    attempt(1, 0, 0, 0, 0, 1, 0, "R12 new cmd clears count, R4 timeout");
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule